// File: doc/BRIEF.md
# Private Timer Interrupt Edge Router

This block sits between a cluster's per-core private timers and watchdogs and the private interrupt inputs of an interrupt controller. Every timer and watchdog drives a level output. The router watches these levels. On each low-to-high transition it raises a single-cycle pending-set pulse toward the core that owns the line. A source that stays high is therefore reported once and is not re-requested on every cycle.

Source lines are numbered from zero, two per core. Shifting the index right by one gives the owning core. The low bit picks one of two fixed private interrupt IDs: 29 for the timer (even line) and 30 for the watchdog (odd line). The output is a per-core pair of pending-set bits indexed by ID minus 29, plus a per-core summary strobe. Only the lines of the configured cores are connected. The lines of the remaining core slots never raise a request.

Top module: `timer_irq_router`

## Requirements
- R1: While reset is asserted, all outputs are 0 and every recorded previous level is cleared. A line that is already high at the first sample after reset produces a pulse.
- R2: A rising edge on connected line i gives a pulse on pend_set bit 2*c+s, where c = i>>1 and s = i&1. Slot 0 carries ID 29 (timer) and slot 1 carries ID 30 (watchdog).
- R3: A line that stays high over consecutive samples produces no further pulse after its first one.
- R4: A falling edge produces no pulse. After at least one low sample, a new rise produces a new pulse.
- R5: When several connected lines rise at the same sample, each one raises its own bit in the same cycle.
- R6: Lines with index 2*NUM_CORES or higher never produce a pulse, whatever their level.
- R7: core_irq[c] is high exactly in the cycles in which either pending bit of core c is high.
- R8: src_level is sampled on the rising clock edge. The pulse is visible for exactly the one cycle that follows the edge at which the rise was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | 2*MAX_CORES | Level outputs; line 2c is core c's timer, line 2c+1 is its watchdog |
| pend_set | output | 2*MAX_CORES | Pending-set pulses; bits [2c+1:2c] belong to core c, indexed by ID-29 |
| core_irq | output | MAX_CORES | Per-core strobe, high when either of the core's pending bits is high |

## Verification
The assertions check several properties on every cycle. A pulse is always preceded by a high sample. No bit pulses twice in a row. Every sampled rise on a connected line is followed by its pulse, and a sampled fall never is. Unconnected bits stay low, and a core strobe only appears with one of that core's bits. The bench's scenarios cover the behaviours that depend on history or on several lines together: the pulse for a line held high across reset release, the re-arming after a one-sample low, simultaneous rises spread over several cores, and the mapping of each line to its exact core and ID slot.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
    localparam int TIMER_ID = 29;
    localparam int WDOG_ID  = 30;

    function automatic int line_core(input int idx);
        return idx >> 1;
    endfunction

    function automatic int line_irq_id(input int idx);
        return TIMER_ID + (idx & 1);
    endfunction
endpackage

// File: rtl/tirq_line_edge.sv
module tirq_line_edge (
    input  logic level_i,
    input  logic prev_i,
    input  logic enable_i,
    output logic pulse_o,
    output logic prev_next_o
);
    // A request fires only when the line is now high and was last seen low.
    always_comb begin
        pulse_o     = enable_i & level_i & ~prev_i;
        prev_next_o = enable_i & level_i;
    end
endmodule

// File: rtl/tirq_core_map.sv
module tirq_core_map #(
    parameter int MAX_CORES = 4
) (
    input  logic [2*MAX_CORES-1:0] pulse_i,
    output logic [2*MAX_CORES-1:0] pend_o,
    output logic [MAX_CORES-1:0]   core_any_o
);
    localparam int LINES = 2 * MAX_CORES;

    for (genvar i = 0; i < LINES; i++) begin : g_route
        localparam int CORE = tirq_pkg::line_core(i);
        localparam int SLOT = tirq_pkg::line_irq_id(i) - tirq_pkg::TIMER_ID;
        assign pend_o[CORE*2 + SLOT] = pulse_i[i];
    end

    for (genvar c = 0; c < MAX_CORES; c++) begin : g_any
        assign core_any_o[c] = pend_o[2*c] | pend_o[2*c+1];
    end
endmodule

// File: rtl/timer_irq_router.sv
module timer_irq_router #(
    parameter int MAX_CORES = 4,
    parameter int NUM_CORES = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*MAX_CORES-1:0] src_level,
    output logic [2*MAX_CORES-1:0] pend_set,
    output logic [MAX_CORES-1:0]   core_irq
);
    localparam int LINES     = 2 * MAX_CORES;
    localparam int CONN_LINES = 2 * NUM_CORES;

    typedef struct packed {
        logic [LINES-1:0]     prev;
        logic [LINES-1:0]     pend;
        logic [MAX_CORES-1:0] core;
    } state_t;

    state_t state_d, state_q;

    logic [LINES-1:0]     pulse_w;
    logic [LINES-1:0]     prev_next_w;
    logic [LINES-1:0]     pend_w;
    logic [MAX_CORES-1:0] core_w;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        tirq_line_edge u_edge (
            .level_i     (src_level[i]),
            .prev_i      (state_q.prev[i]),
            .enable_i    (1'(i < CONN_LINES)),
            .pulse_o     (pulse_w[i]),
            .prev_next_o (prev_next_w[i])
        );
    end

    tirq_core_map #(.MAX_CORES(MAX_CORES)) u_map (
        .pulse_i    (pulse_w),
        .pend_o     (pend_w),
        .core_any_o (core_w)
    );

    always_comb begin
        state_d      = state_q;
        state_d.prev = prev_next_w;
        state_d.pend = pend_w;
        state_d.core = core_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pend_set = state_q.pend;
    assign core_irq = state_q.core;
endmodule

// File: rtl/tirq_router_chk.sv
module tirq_router_chk #(
    parameter int MAX_CORES = 4,
    parameter int NUM_CORES = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [2*MAX_CORES-1:0] src_level,
    input logic [2*MAX_CORES-1:0] pend_set,
    input logic [MAX_CORES-1:0]   core_irq
);
    localparam int LINES      = 2 * MAX_CORES;
    localparam int CONN_LINES = 2 * NUM_CORES;

    for (genvar i = 0; i < LINES; i++) begin : g_bit
        if (i < CONN_LINES) begin : g_conn
            assert_pulse_after_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
                pend_set[i] |-> $past(src_level[i]));
            assert_no_repeat_R3: assert property (@(posedge clk) disable iff (!rst_n)
                pend_set[i] |=> !pend_set[i]);
            assert_fall_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(src_level[i]) |=> !pend_set[i]);
            assert_rise_reported_R8: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(src_level[i]) |=> pend_set[i]);
        end else begin : g_open
            assert_open_line_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !pend_set[i]);
        end
    end

    for (genvar c = 0; c < MAX_CORES; c++) begin : g_core
        assert_strobe_has_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
            core_irq[c] |-> (pend_set[2*c] || pend_set[2*c+1]));
    end
endmodule

bind timer_irq_router tirq_router_chk #(
    .MAX_CORES(MAX_CORES),
    .NUM_CORES(NUM_CORES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_level (src_level),
    .pend_set  (pend_set),
    .core_irq  (core_irq)
);

// File: tb/timer_irq_router_bench.sv
module timer_irq_router_bench;
    localparam int MAX_CORES = 4;
    localparam int NUM_CORES = 3;
    localparam int LINES     = 2 * MAX_CORES;
    localparam logic [LINES-1:0] MASK = LINES'((1 << (2 * NUM_CORES)) - 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [LINES-1:0]     src = '0;
    logic [LINES-1:0]     pend_set;
    logic [MAX_CORES-1:0] core_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [LINES-1:0] model_prev = '0;
    logic [LINES-1:0] exp_q[$];
    string            tag_q[$];

    always #5 clk = ~clk;

    timer_irq_router #(.MAX_CORES(MAX_CORES), .NUM_CORES(NUM_CORES)) u_timer_irq_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_level (src),
        .pend_set  (pend_set),
        .core_irq  (core_irq)
    );

    function automatic logic [MAX_CORES-1:0] strobes(input logic [LINES-1:0] p);
        logic [MAX_CORES-1:0] r;
        for (int c = 0; c < MAX_CORES; c++) r[c] = p[2*c] | p[2*c+1];
        return r;
    endfunction

    task automatic step(input logic [LINES-1:0] v, input string tag);
        @(negedge clk);
        src = v;
        exp_q.push_back(v & ~model_prev & MASK);
        tag_q.push_back(tag);
        model_prev = v & MASK;
    endtask

    // Monitor: compares each registered result one edge after its stimulus.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [LINES-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (pend_set !== e) begin
                    errors++;
                    $display("FAIL %s pend_set actual=%b expected=%b", t, pend_set, e);
                end
                checks++;
                if (core_irq !== strobes(e)) begin
                    errors++;
                    $display("FAIL R7 (%s) core_irq actual=%b expected=%b", t, core_irq, strobes(e));
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        src = 8'h01;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (pend_set !== '0 || core_irq !== '0) begin
            errors++;
            $display("FAIL R1 reset outputs actual=%b/%b expected=0/0", pend_set, core_irq);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;
        step(8'h01, "R1 high at release");
        step(8'h01, "R3 held high");
        step(8'h01, "R3 held high");
        step(8'h00, "R4 fall");
        step(8'h01, "R4 rerise");
        step(8'h02, "R2 core0 watchdog");
        step(8'h00, "R4 fall");
        step(8'h04, "R2 core1 timer");
        step(8'h08, "R2 core1 watchdog");
        step(8'h00, "R4 fall");
        step(8'h30, "R5 core2 both");
        step(8'h3F, "R5 remaining rise");
        step(8'h3F, "R3 all held");
        step(8'h00, "R4 all fall");
        step(8'hC0, "R6 open lines");
        step(8'hFF, "R5 R6 all rise");
        step(8'hFF, "R3 all held");
        step(8'h00, "R4 all fall");
        step(8'h10, "R8 rise");
        step(8'h00, "R8 one low");
        step(8'h10, "R8 rise again");
        step(8'h15, "R5 mixed");
        step(8'h00, "R4 idle");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule